// File: doc/BRIEF.md
# Conditional Shifted-Operand ALU Stage

This block is the execute stage of a 32-bit load-store RISC core. Every cycle it can take one decoded data-processing operation. That operation is a first register operand plus a second operand. The second operand is either an immediate or a register value, and the register value may first pass through a left-logical or right-arithmetic shifter. The shift amount comes from an immediate field or from the low byte of another register.

The stage holds the N, Z, C and V flags. Before an operation is allowed to act, its 4-bit condition is tested against the current flags. An operation that passes produces a registered result and a write strobe for the destination register. When the destination index is the program counter, it produces a one-cycle jump pulse instead, with the result as the target. The flags change only when the operation carries a set-flags bit.

Fetch, decode, the register file and memory access sit outside this block. The stage drives the register-file write port and the front end's redirect.

Top module: `cae_stage`

## Requirements
- R1: The condition field is decoded as EQ=0000 (Z), NE=0001 (!Z), MI=0100 (N), PL=0101 (!N), GE=1010 (N==V), LT=1011 (N!=V), GT=1100 (!Z and N==V), LE=1101 (Z or N!=V) and AL=1110 (always). All other codes never execute.
- R2: An operation whose condition fails causes no register write, no jump and no change of flags.
- R3: `flags_o` is {N,Z,C,V}, with N in bit 3 and V in bit 0. It changes only on an executed operation with `set_flags_i` high. N is the result's bit 31, and Z is set when the result is zero.
- R4: The `op_i` codes are MOV=0 (operand2), ADD=1 (op1+op2), SUB=2 (op1-op2), RSB=3 (op2-op1) and RSC=4 (op2-op1-NOT C). The result appears on `result_o`.
- R5: For ADD, SUB, RSB and RSC, the new C is the adder carry-out. On subtraction this means "no borrow". The new V is signed overflow. RSC uses the C flag held before the operation.
- R6: For MOV, the new C is the shifter carry-out and V keeps its value. When the second operand is the immediate (`op2_is_imm_i`=1), it is not shifted and C keeps its value.
- R7: With an immediate shift amount n in 1..31, LSL (`shift_asr_i`=0) gives x<<n with carry x[32-n]. ASR (`shift_asr_i`=1) gives the sign-filling x>>n with carry x[n-1].
- R8: A register shift amount uses only the low 8 bits of `rs_val_i`. An amount of 0 passes the value through and keeps C. LSL by 32 gives 0 with carry x[0], and LSL by more than 32 gives 0 with carry 0. ASR by 32 or more gives all sign bits with carry x[31].
- R9: An executed operation with `rd_i`=15 raises `jump_o` for one cycle with the target on `result_o`. In that cycle `wr_en_o` stays low.
- R10: Outputs are registered and appear the cycle after the operation is presented. The condition of each operation sees the flags left by the operation before it.
- R11: With `valid_i` low, or with a reserved `op_i` code (5 to 7), nothing is written, no jump is raised and the flags keep their value.
- R12: During and after reset, `wr_en_o`, `jump_o`, `wr_idx_o`, `result_o` and `flags_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An operation is presented this cycle |
| cond_i | input | 4 | Condition code |
| op_i | input | 3 | Operation code |
| set_flags_i | input | 1 | Operation may update the flags |
| rd_i | input | 4 | Destination register index |
| rn_val_i | input | 32 | First operand |
| op2_is_imm_i | input | 1 | Second operand is `imm_i`, unshifted |
| imm_i | input | 32 | Immediate second operand |
| rm_val_i | input | 32 | Register second operand, before shifting |
| shift_asr_i | input | 1 | 0: logical left, 1: arithmetic right |
| shift_by_reg_i | input | 1 | Shift amount comes from `rs_val_i` |
| shift_imm_i | input | 5 | Immediate shift amount |
| rs_val_i | input | 32 | Register holding the shift amount |
| wr_en_o | output | 1 | Register write strobe |
| wr_idx_o | output | 4 | Register write index |
| result_o | output | 32 | Result or jump target |
| jump_o | output | 1 | Computed jump taken |
| flags_o | output | 4 | Current N,Z,C,V |

## Verification
The bench runs chains of operations where each condition depends on flags that an earlier operation set. A stage that evaluated GE, LT, GT or LE with the wrong signed relation would write when it should stay quiet, or the reverse. The bench also probes the shifter edges: amount zero from a register, an amount whose set bit lies above the low byte, exactly 32 and beyond 32. A shifter that wrapped the amount modulo 32, or took the carry from the wrong bit, shows a wrong result or a wrong C. Further cases cover RSC with both carry states, a move that must keep V, an overflow on add and subtract, and a jump that must not also raise the write strobe. A design that dropped the old carry into RSC, or cleared V on moves, ends up with a mismatched flag nibble.

// File: rtl/cae_pkg.sv
package cae_pkg;

  typedef enum logic [3:0] {
    CC_EQ = 4'h0,
    CC_NE = 4'h1,
    CC_MI = 4'h4,
    CC_PL = 4'h5,
    CC_GE = 4'hA,
    CC_LT = 4'hB,
    CC_GT = 4'hC,
    CC_LE = 4'hD,
    CC_AL = 4'hE
  } cond_e;

  typedef enum logic [2:0] {
    OP_MOV = 3'd0,
    OP_ADD = 3'd1,
    OP_SUB = 3'd2,
    OP_RSB = 3'd3,
    OP_RSC = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/cae_cond_eval.sv
module cae_cond_eval
  import cae_pkg::*;
(
  input  logic [3:0] cond_i,
  input  flags_t     flags_i,
  output logic       pass_o
);

  logic sign_ok;
  assign sign_ok = (flags_i.n == flags_i.v);

  always_comb begin
    case (cond_i)
      CC_EQ:   pass_o = flags_i.z;
      CC_NE:   pass_o = !flags_i.z;
      CC_MI:   pass_o = flags_i.n;
      CC_PL:   pass_o = !flags_i.n;
      CC_GE:   pass_o = sign_ok;
      CC_LT:   pass_o = !sign_ok;
      CC_GT:   pass_o = !flags_i.z && sign_ok;
      CC_LE:   pass_o = flags_i.z || !sign_ok;
      CC_AL:   pass_o = 1'b1;
      default: pass_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/cae_shifter.sv
module cae_shifter #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned SHREG_W = 8
) (
  input  logic [XLEN-1:0]    val_i,
  input  logic               asr_i,
  input  logic [SHREG_W-1:0] amt_i,
  input  logic               c_i,
  output logic [XLEN-1:0]    val_o,
  output logic               c_o
);

  // amount is saturated at XLEN; one extra bit on each side catches the carry
  localparam int unsigned CAPW = $clog2(XLEN) + 1;

  logic [CAPW-1:0]    amt_cap;
  logic               amt_over;
  logic [XLEN:0]      lsl_w;
  logic signed [XLEN:0] asr_w;

  assign amt_over = (amt_i > SHREG_W'(XLEN));
  assign amt_cap  = (amt_i >= SHREG_W'(XLEN)) ? CAPW'(XLEN) : amt_i[CAPW-1:0];
  assign lsl_w    = {1'b0, val_i} << amt_cap;
  assign asr_w    = $signed({val_i, 1'b0}) >>> amt_cap;

  always_comb begin
    if (amt_i == '0) begin
      val_o = val_i;
      c_o   = c_i;
    end else if (!asr_i) begin
      val_o = lsl_w[XLEN-1:0];
      c_o   = amt_over ? 1'b0 : lsl_w[XLEN];
    end else begin
      val_o = asr_w[XLEN:1];
      c_o   = asr_w[0];
    end
  end

endmodule

// File: rtl/cae_alu_core.sv
module cae_alu_core
  import cae_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            c_i,
  input  logic            sh_c_i,
  input  logic            v_i,
  output logic [XLEN-1:0] res_o,
  output flags_t          flags_o,
  output logic            legal_o
);

  logic [XLEN-1:0] x, y;
  logic            cin;
  logic            arith;
  logic [XLEN:0]   sum;
  logic            add_v;

  // one adder; subtraction forms swap and invert the inputs
  always_comb begin
    x       = a_i;
    y       = b_i;
    cin     = 1'b0;
    arith   = 1'b1;
    legal_o = 1'b1;
    case (op_i)
      OP_MOV: arith = 1'b0;
      OP_ADD: ;
      OP_SUB: begin y = ~b_i; cin = 1'b1; end
      OP_RSB: begin x = b_i; y = ~a_i; cin = 1'b1; end
      OP_RSC: begin x = b_i; y = ~a_i; cin = c_i; end
      default: begin arith = 1'b0; legal_o = 1'b0; end
    endcase
  end

  assign sum   = {1'b0, x} + {1'b0, y} + {{XLEN{1'b0}}, cin};
  assign add_v = (x[XLEN-1] == y[XLEN-1]) && (sum[XLEN-1] != x[XLEN-1]);

  always_comb begin
    res_o     = arith ? sum[XLEN-1:0] : b_i;
    flags_o.n = res_o[XLEN-1];
    flags_o.z = (res_o == '0);
    flags_o.c = arith ? sum[XLEN] : sh_c_i;
    flags_o.v = arith ? add_v : v_i;
  end

endmodule

// File: rtl/cae_stage.sv
module cae_stage
  import cae_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned REG_W   = 4,
  parameter int unsigned PC_IDX  = 15,
  parameter int unsigned SHIMM_W = 5,
  parameter int unsigned SHREG_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [3:0]         cond_i,
  input  logic [2:0]         op_i,
  input  logic               set_flags_i,
  input  logic [REG_W-1:0]   rd_i,
  input  logic [XLEN-1:0]    rn_val_i,
  input  logic               op2_is_imm_i,
  input  logic [XLEN-1:0]    imm_i,
  input  logic [XLEN-1:0]    rm_val_i,
  input  logic               shift_asr_i,
  input  logic               shift_by_reg_i,
  input  logic [SHIMM_W-1:0] shift_imm_i,
  input  logic [XLEN-1:0]    rs_val_i,
  output logic               wr_en_o,
  output logic [REG_W-1:0]   wr_idx_o,
  output logic [XLEN-1:0]    result_o,
  output logic               jump_o,
  output logic [3:0]         flags_o
);

  localparam logic [REG_W-1:0] PC_SEL = REG_W'(PC_IDX);

  flags_t          flags_q, flags_d;
  logic            cond_pass;
  logic [SHREG_W-1:0] sh_amt;
  logic [XLEN-1:0] sh_val;
  logic            sh_c;
  logic [XLEN-1:0] op2;
  logic            op2_c;
  logic [XLEN-1:0] alu_res;
  logic            legal;
  logic            exec;
  logic            to_pc;
  logic            unused_rs;

  assign unused_rs = ^rs_val_i[XLEN-1:SHREG_W];

  cae_cond_eval u_cond (
    .cond_i  (cond_i),
    .flags_i (flags_q),
    .pass_o  (cond_pass)
  );

  assign sh_amt = shift_by_reg_i ? rs_val_i[SHREG_W-1:0] : SHREG_W'(shift_imm_i);

  cae_shifter #(.XLEN(XLEN), .SHREG_W(SHREG_W)) u_shift (
    .val_i (rm_val_i),
    .asr_i (shift_asr_i),
    .amt_i (sh_amt),
    .c_i   (flags_q.c),
    .val_o (sh_val),
    .c_o   (sh_c)
  );

  // immediate operand bypasses the shifter and leaves C alone
  assign op2   = op2_is_imm_i ? imm_i : sh_val;
  assign op2_c = op2_is_imm_i ? flags_q.c : sh_c;

  cae_alu_core #(.XLEN(XLEN)) u_alu (
    .op_i    (op_i),
    .a_i     (rn_val_i),
    .b_i     (op2),
    .c_i     (flags_q.c),
    .sh_c_i  (op2_c),
    .v_i     (flags_q.v),
    .res_o   (alu_res),
    .flags_o (flags_d),
    .legal_o (legal)
  );

  assign exec  = valid_i && cond_pass && legal;
  assign to_pc = (rd_i == PC_SEL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q  <= '0;
      wr_en_o  <= 1'b0;
      jump_o   <= 1'b0;
      wr_idx_o <= '0;
      result_o <= '0;
    end else begin
      wr_en_o <= exec && !to_pc;
      jump_o  <= exec && to_pc;
      if (exec) begin
        wr_idx_o <= rd_i;
        result_o <= alu_res;
        if (set_flags_i) flags_q <= flags_d;
      end
    end
  end

  assign flags_o = flags_q;

  // R2
  cond_fail_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !cond_pass) |=> (!wr_en_o && !jump_o && flags_o == $past(flags_o)));

  // R3
  flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && set_flags_i) |=> $stable(flags_o));

  // R9
  jump_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_o && jump_o));

  // R1
  al_exec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_i == CC_AL && op_i <= OP_RSC) |=> (wr_en_o || jump_o));

  // R6
  mov_v_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_pass && op_i == OP_MOV) |=> (flags_o[0] == $past(flags_o[0])));

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || op_i > OP_RSC) |=> (!wr_en_o && !jump_o && $stable(flags_o)));

endmodule

// File: tb/cae_stage_test.sv
module cae_stage_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  cond = 4'hE;
  logic [2:0]  op = '0;
  logic        sflag = 1'b0;
  logic [3:0]  rd = '0;
  logic [31:0] rn = '0;
  logic        isimm = 1'b0;
  logic [31:0] imm = '0;
  logic [31:0] rm = '0;
  logic        asr = 1'b0;
  logic        byreg = 1'b0;
  logic [4:0]  shimm = '0;
  logic [31:0] rs = '0;
  logic        wr_en, jump;
  logic [3:0]  wr_idx, flags;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  cae_stage uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .cond_i(cond), .op_i(op),
    .set_flags_i(sflag), .rd_i(rd), .rn_val_i(rn), .op2_is_imm_i(isimm),
    .imm_i(imm), .rm_val_i(rm), .shift_asr_i(asr), .shift_by_reg_i(byreg),
    .shift_imm_i(shimm), .rs_val_i(rs), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .result_o(result), .jump_o(jump), .flags_o(flags)
  );

  typedef struct packed {
    logic [3:0]  cond;
    logic [2:0]  op;
    logic        s;
    logic [3:0]  rd;
    logic [31:0] rn;
    logic        isimm;
    logic [31:0] imm;
    logic [31:0] rm;
    logic        asr;
    logic        byreg;
    logic [4:0]  shimm;
    logic [31:0] rs;
    logic        ewr;
    logic        ejmp;
    logic [31:0] eres;
    logic [3:0]  eflags;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  // flags column is {N,Z,C,V}; each row runs on the flags left by the row before
  localparam vec_t VECS [NV] = '{
    '{4'hE,3'd0,1'b1,4'd1, 32'h0,1'b1,32'h0, 32'h0,1'b0,1'b0,5'd0,32'h0, 1'b1,1'b0,32'h0,4'b0100,4'd6},              // R6 MOVS imm
    '{4'h0,3'd1,1'b0,4'd2, 32'd5,1'b1,32'd7, 32'h0,1'b0,1'b0,5'd0,32'h0, 1'b1,1'b0,32'd12,4'b0100,4'd1},             // R1 EQ pass
    '{4'h1,3'd0,1'b0,4'd3, 32'h0,1'b1,32'd9, 32'h0,1'b0,1'b0,5'd0,32'h0, 1'b0,1'b0,32'h0,4'b0100,4'd2},              // R2 NE fail
    '{4'hE,3'd2,1'b1,4'd4, 32'd3,1'b1,32'd5, 32'h0,1'b0,1'b0,5'd0,32'h0, 1'b1,1'b0,32'hFFFF_FFFE,4'b1000,4'd5},      // R5 SUBS borrow
    '{4'h4,3'd3,1'b0,4'd5, 32'd10,1'b1,32'h0, 32'h0,1'b0,1'b0,5'd0,32'h0, 1'b1,1'b0,32'hFFFF_FFF6,4'b1000,4'd4},     // R4 MI RSB negate
    '{4'hB,3'd0,1'b0,4'd6, 32'h0,1'b0,32'h0, 32'h3,1'b0,1'b0,5'd4,32'h0, 1'b1,1'b0,32'h30,4'b1000,4'd7},             // R7 LT, LSL#4
    '{4'hA,3'd1,1'b0,4'd7, 32'd1,1'b1,32'd1, 32'h0,1'b0,1'b0,5'd0,32'h0, 1'b0,1'b0,32'h0,4'b1000,4'd1},              // R1 GE fail
    '{4'hE,3'd1,1'b1,4'd8, 32'h7FFF_FFFF,1'b1,32'd1, 32'h0,1'b0,1'b0,5'd0,32'h0, 1'b1,1'b0,32'h8000_0000,4'b1001,4'd5}, // R5 ADDS overflow
    '{4'hA,3'd0,1'b1,4'd9, 32'h0,1'b0,32'h0, 32'h8000_0001,1'b1,1'b1,5'd0,32'd1, 1'b1,1'b0,32'hC000_0000,4'b1011,4'd6}, // R6 GE, ASR reg 1
    '{4'hC,3'd4,1'b1,4'd10,32'd5,1'b1,32'd20, 32'h0,1'b0,1'b0,5'd0,32'h0, 1'b1,1'b0,32'd15,4'b0010,4'd5},            // R5 GT RSCS C=1
    '{4'hD,3'd0,1'b1,4'd11,32'h0,1'b1,32'h0, 32'h0,1'b0,1'b0,5'd0,32'h0, 1'b0,1'b0,32'h0,4'b0010,4'd2},              // R2 LE fail
    '{4'h5,3'd4,1'b1,4'd12,32'd5,1'b1,32'd5, 32'h0,1'b0,1'b0,5'd0,32'h0, 1'b1,1'b0,32'h0,4'b0110,4'd5},              // R5 PL RSCS zero
    '{4'hE,3'd4,1'b1,4'd1, 32'd1,1'b1,32'h0, 32'h0,1'b0,1'b0,5'd0,32'h0, 1'b1,1'b0,32'hFFFF_FFFF,4'b1000,4'd5},      // R5 RSCS borrow
    '{4'hE,3'd4,1'b0,4'd2, 32'd1,1'b1,32'd5, 32'h0,1'b0,1'b0,5'd0,32'h0, 1'b1,1'b0,32'd3,4'b1000,4'd4},              // R4 RSC C=0
    '{4'hE,3'd0,1'b1,4'd3, 32'h0,1'b0,32'h0, 32'hFFFF_0000,1'b0,1'b1,5'd0,32'd32, 1'b1,1'b0,32'h0,4'b0100,4'd8},     // R8 LSL 32
    '{4'hE,3'd0,1'b1,4'd3, 32'h0,1'b0,32'h0, 32'h8000_0000,1'b1,1'b1,5'd0,32'd40, 1'b1,1'b0,32'hFFFF_FFFF,4'b1010,4'd8}, // R8 ASR 40
    '{4'hE,3'd0,1'b1,4'd4, 32'h0,1'b0,32'h0, 32'h1234,1'b0,1'b1,5'd0,32'h100, 1'b1,1'b0,32'h1234,4'b0010,4'd8},      // R8 low byte 0
    '{4'hE,3'd1,1'b0,4'd15,32'h1000,1'b0,32'h0, 32'h2,1'b0,1'b0,5'd2,32'h0, 1'b0,1'b1,32'h1008,4'b0010,4'd9},        // R9 jump
    '{4'h0,3'd0,1'b0,4'd15,32'h0,1'b1,32'h4, 32'h0,1'b0,1'b0,5'd0,32'h0, 1'b0,1'b0,32'h0,4'b0010,4'd9},              // R9 jump, EQ fail
    '{4'hE,3'd0,1'b1,4'd5, 32'h0,1'b0,32'h0, 32'h3,1'b0,1'b1,5'd0,32'd33, 1'b1,1'b0,32'h0,4'b0100,4'd8},             // R8 LSL 33
    '{4'hE,3'd0,1'b1,4'd5, 32'h0,1'b0,32'h0, 32'h3,1'b0,1'b0,5'd31,32'h0, 1'b1,1'b0,32'h8000_0000,4'b1010,4'd7},     // R7 LSL#31
    '{4'hE,3'd2,1'b1,4'd6, 32'h8000_0000,1'b1,32'd1, 32'h0,1'b0,1'b0,5'd0,32'h0, 1'b1,1'b0,32'h7FFF_FFFF,4'b0011,4'd5}, // R5 SUBS overflow
    '{4'hE,3'd7,1'b1,4'd7, 32'd1,1'b1,32'd1, 32'h0,1'b0,1'b0,5'd0,32'h0, 1'b0,1'b0,32'h0,4'b0011,4'd11},             // R11 reserved op
    '{4'hE,3'd0,1'b1,4'd8, 32'h0,1'b0,32'h0, 32'hF000_0010,1'b1,1'b0,5'd4,32'h0, 1'b1,1'b0,32'hFF00_0001,4'b1001,4'd7}, // R7 ASR#4
    '{4'hE,3'd2,1'b1,4'd9, 32'd5,1'b1,32'd5, 32'h0,1'b0,1'b0,5'd0,32'h0, 1'b1,1'b0,32'h0,4'b0110,4'd3},              // R3 SUBS zero
    '{4'hE,3'd0,1'b1,4'd10,32'h0,1'b1,32'h8000_0000, 32'h0,1'b0,1'b0,5'd0,32'h0, 1'b1,1'b0,32'h8000_0000,4'b1010,4'd6} // R6 imm keeps C
  };

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    cond = v.cond; op = v.op; sflag = v.s; rd = v.rd; rn = v.rn;
    isimm = v.isimm; imm = v.imm; rm = v.rm; asr = v.asr; byreg = v.byreg;
    shimm = v.shimm; rs = v.rs;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk);
    check("R12", "wr_en", 32'(wr_en), 32'h0);
    check("R12", "jump", 32'(jump), 32'h0);
    check("R12", "result", result, 32'h0);
    check("R12", "flags", 32'(flags), 32'h0);
    rst_n = 1'b1;

    // R10 one vector per cycle, checked one cycle later
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      valid = 1'b1;
      @(negedge clk);
      valid = 1'b0;
      begin
        string tag;
        tag = $sformatf("R%0d v%0d", VECS[i].req, i);
        check(tag, "wr_en", 32'(wr_en), 32'(VECS[i].ewr));
        check(tag, "jump", 32'(jump), 32'(VECS[i].ejmp));
        if (VECS[i].ewr) check(tag, "wr_idx", 32'(wr_idx), 32'(VECS[i].rd));
        if (VECS[i].ewr || VECS[i].ejmp) check(tag, "result", result, VECS[i].eres);
        check(tag, "flags", 32'(flags), 32'(VECS[i].eflags));
      end
    end

    // R10 back-to-back: SUBS to zero then EQ move in the next cycle
    @(negedge clk);
    drive(VECS[24]);
    valid = 1'b1;
    @(negedge clk);
    cond = 4'h0; op = 3'd0; sflag = 1'b0; rd = 4'd11; isimm = 1'b1; imm = 32'h55;
    @(negedge clk);
    valid = 1'b0;
    check("R10", "back-to-back wr_en", 32'(wr_en), 32'h1);
    check("R10", "back-to-back result", result, 32'h55);

    // R9 jump pulse lasts one cycle
    @(negedge clk);
    drive(VECS[17]);
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check("R9", "jump high", 32'(jump), 32'h1);
    @(negedge clk);
    check("R9", "jump pulse ends", 32'(jump), 32'h0);

    // R11 valid low: flags 0110 stay, no write
    @(negedge clk);
    cond = 4'hE; op = 3'd0; sflag = 1'b1; rd = 4'd1; isimm = 1'b1; imm = 32'h8000_0000;
    valid = 1'b0;
    @(negedge clk);
    check("R11", "idle wr_en", 32'(wr_en), 32'h0);
    check("R11", "idle flags", 32'(flags), 32'b0110);

    // R1 unlisted condition code never executes
    cond = 4'hF; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check("R1", "code F wr_en", 32'(wr_en), 32'h0);
    check("R1", "code F flags", 32'(flags), 32'b0110);

    // R12 reset again clears flags
    rst_n = 1'b0;
    @(negedge clk);
    check("R12", "re-reset flags", 32'(flags), 32'h0);
    check("R12", "re-reset result", result, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule